// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous on-chip logic use an external byte-wide static RAM that has no clock input. The requester presents a read or a write with an address, write data and an address-decode hit. The controller then builds the whole bus cycle out of internal clock cycles. Chip select goes low first, with the address and any write data already on the pins. The output-enable or write-enable strobe is held low for a programmable number of cycles. The strobe is then released while chip select, address and data stay put for one more cycle. A one-cycle `done` pulse ends the access and carries the read byte.

The strobe width is the larger of the programmed wait count and a floor that is derived from the device access time and the clock period, so a register setting that is too small can never shorten an access below what the part needs. The data bus is split into output, output-enable and input pins. The output driver is on only inside a write cycle, and a write that follows a read waits one extra dead cycle. When refresh is enabled, a timer forces a window with chip select high at a fixed interval, so that DRAM-based parts behind an SRAM-style interface can refresh themselves. The window waits for any access in flight to finish, and `busy` holds off new requests until the window is over.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, and busy and done are 0.
- R2: A request with req_sel low is ignored. Chip select stays high, no done pulse follows, and memory contents are unchanged.
- R3: Every access has exactly one cycle with chip select low and both strobes high before the strobe, and exactly one such cycle after it. mem_oe_n and mem_we_n are never low together, and never low while chip select is high.
- R4: The strobe (mem_oe_n for a read, mem_we_n for a write) stays low for max(cfg_wait, MINW)+1 cycles, where MINW = ceil(ACCESS_PS/CLK_PS)-1, or 0 if that is negative. The default is 15 ns at 10 ns, which gives MINW = 1.
- R5: On a read, rd_data takes the mem_dq_i value present in the last strobe cycle. done is high for exactly one cycle, the cycle after the strobe, with chip select still low.
- R6: mem_dq_oe is 1 only while a write access holds chip select low and mem_oe_n high. mem_addr and mem_dq_o are stable while chip select is low.
- R7: A write that directly follows a read has at least two cycles with chip select high between the read's done cycle and its own chip-select assertion. Other back-to-back accesses need only one such cycle.
- R8: With refresh enabled, a window begins every REF_INTERVAL cycles when the bus is idle. During the window busy is high for REF_GAP+1 cycles and chip select is high.
- R9: A request presented while a refresh window is pending or running is stalled by busy. It is accepted in the first cycle after the window and completes normally. For a read, its chip select falls REF_GAP+2 cycles after busy rose.
- R10: A refresh window never splits an access. Chip select stays low from its first assertion in an access until that access's done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until accepted |
| req_sel | input | 1 | Address decode hit for this memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Byte address |
| req_wdata | input | DATA_W (8) | Write byte |
| cfg_wait | input | WAIT_W (4) | Programmed strobe wait count |
| busy | output | 1 | Request cannot be accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W (8) | Byte read by the last read |
| mem_addr | output | ADDR_W (17) | Memory address bus |
| mem_dq_o | output | DATA_W (8) | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output driver enable |
| mem_dq_i | input | DATA_W (8) | Data bus input value |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The bench keeps the default 17-bit address, 8-bit data, 4-bit wait count and 15 ns / 10 ns timing, so the strobe floor is one cycle. A wait setting of 0 therefore has to be raised, and the memory model returns junk unless the strobe has been low for that long. The refresh interval is cut to 50 cycles and the window to 3 cycles. This lets the bench time several refresh periods, land a request inside a window, and run a 16-cycle strobe that crosses a refresh deadline, all within a short run.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_GAP
  } seq_state_e;

  // Extra strobe cycles beyond the first that cover the device access time.
  function automatic int unsigned strobe_floor(int unsigned access_ps,
                                               int unsigned clk_ps);
    int unsigned cyc;
    cyc = (access_ps + clk_ps - 1) / clk_ps;
    return (cyc > 0) ? cyc - 1 : 0;
  endfunction

  // Cycles from a chip-select low run start to its end, for the largest wait.
  function automatic int unsigned longest_cs_run(int unsigned wait_w);
    return (1 << wait_w) + 2;
  endfunction

endpackage

// File: rtl/sram_refresh_timer.sv
module sram_refresh_timer #(
  parameter bit REF_EN       = 1'b1,
  parameter int REF_INTERVAL = 1400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gap_start,
  output logic ref_pend
);
  localparam int CW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;

  generate
    if (REF_EN) begin : g_timer
      logic [CW-1:0] tick;
      logic          wrap;
      assign wrap = (tick == CW'(REF_INTERVAL - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tick     <= '0;
          ref_pend <= 1'b0;
        end else begin
          tick <= wrap ? '0 : tick + 1'b1;
          if (wrap)           ref_pend <= 1'b1;
          else if (gap_start) ref_pend <= 1'b0;
        end
      end
    end else begin : g_none
      assign ref_pend = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int WAIT_W    = 4,
  parameter int ACCESS_PS = 15000,
  parameter int CLK_PS    = 10000,
  parameter int REF_GAP   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_sel,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              ref_pend,
  input  logic [DATA_W-1:0] mem_dq_i,
  output seq_state_e        state,
  output logic              wr_q,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              gap_start,
  output logic              acc_start,
  output logic              strobe_last
);
  localparam int              MINW   = strobe_floor(ACCESS_PS, CLK_PS);
  localparam logic [WAIT_W-1:0] MINW_V = WAIT_W'(MINW);
  localparam int              GW     = $clog2(REF_GAP + 1);

  logic [WAIT_W-1:0] cnt;
  logic [WAIT_W-1:0] eff_wait;
  logic [GW-1:0]     gap_cnt;
  logic              last_rd;

  assign eff_wait    = (cfg_wait < MINW_V) ? MINW_V : cfg_wait;
  assign busy        = (state != ST_IDLE) || ref_pend;
  assign done        = (state == ST_HOLD);
  assign gap_start   = (state == ST_IDLE) && ref_pend;
  assign acc_start   = (state == ST_IDLE) && !ref_pend && req_valid && req_sel;
  assign strobe_last = (state == ST_STROBE) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wr_q    <= 1'b0;
      last_rd <= 1'b0;
      cnt     <= '0;
      gap_cnt <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_data <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (gap_start) begin
            state   <= ST_GAP;
            gap_cnt <= GW'(REF_GAP - 1);
          end else if (acc_start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
            cnt     <= eff_wait;
            state   <= (req_write && last_rd) ? ST_TURN : ST_SETUP;
          end
        end
        ST_TURN:  state <= ST_SETUP;
        ST_SETUP: state <= ST_STROBE;
        ST_STROBE: begin
          if (strobe_last) begin
            if (!wr_q) rd_data <= mem_dq_i;
            state <= ST_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          last_rd <= !wr_q;
          state   <= ST_IDLE;
        end
        ST_GAP: begin
          if (gap_cnt == '0) state <= ST_IDLE;
          else               gap_cnt <= gap_cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
(
  input  seq_state_e state,
  input  logic       wr_q,
  output logic       cs_n,
  output logic       oe_n,
  output logic       we_n,
  output logic       dq_oe
);
  logic in_cycle;
  assign in_cycle = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign cs_n  = !in_cycle;
  assign oe_n  = !((state == ST_STROBE) && !wr_q);
  assign we_n  = !((state == ST_STROBE) &&  wr_q);
  assign dq_oe = in_cycle && wr_q;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int WAIT_W       = 4,
  parameter int ACCESS_PS    = 15000,
  parameter int CLK_PS       = 10000,
  parameter bit REF_EN       = 1'b1,
  parameter int REF_INTERVAL = 1400,
  parameter int REF_GAP      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_sel,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);
  seq_state_e state;
  logic       wr_q;
  logic       ref_pend;
  logic       gap_start;
  logic       acc_start;
  logic       strobe_last;

  sram_refresh_timer #(
    .REF_EN      (REF_EN),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .gap_start(gap_start),
    .ref_pend (ref_pend)
  );

  sram_access_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WAIT_W   (WAIT_W),
    .ACCESS_PS(ACCESS_PS),
    .CLK_PS   (CLK_PS),
    .REF_GAP  (REF_GAP)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_sel    (req_sel),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .cfg_wait   (cfg_wait),
    .ref_pend   (ref_pend),
    .mem_dq_i   (mem_dq_i),
    .state      (state),
    .wr_q       (wr_q),
    .busy       (busy),
    .done       (done),
    .rd_data    (rd_data),
    .addr_q     (mem_addr),
    .wdata_q    (mem_dq_o),
    .gap_start  (gap_start),
    .acc_start  (acc_start),
    .strobe_last(strobe_last)
  );

  sram_pin_drive u_pins (
    .state(state),
    .wr_q (wr_q),
    .cs_n (mem_cs_n),
    .oe_n (mem_oe_n),
    .we_n (mem_we_n),
    .dq_oe(mem_dq_oe)
  );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done,
  input logic              gap_start,
  input logic              acc_start,
  input logic              strobe_last
);
  localparam int MAX_RUN = longest_cs_run(WAIT_W);
  localparam int RW      = $clog2(MAX_RUN + 2);

  logic [RW-1:0] cs_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cs_run <= '0;
    else if (mem_cs_n) cs_run <= '0;
    else if (cs_run != '1) cs_run <= cs_run + 1'b1;
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

  assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_oe_n) || $fell(mem_we_n)) |-> !$past(mem_cs_n));

  assert_latch_in_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_last |=> done);

  assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_cs_n && mem_oe_n && mem_we_n));

  assert_drive_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_cs_n && mem_oe_n));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  assert_cs_run_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cs_run) <= MAX_RUN);

  assert_gap_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gap_start |=> (busy && mem_cs_n));

  assert_no_split_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gap_start |-> (mem_cs_n && !acc_start));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .WAIT_W(WAIT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .busy       (busy),
  .done       (done),
  .gap_start  (gap_start),
  .acc_start  (acc_start),
  .strobe_last(strobe_last)
);

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;
  localparam int INTV = 50;
  localparam int GAP  = 3;
  // 15 ns access at a 10 ns clock: strobe must span two cycles, so floor = 1.
  localparam int TB_FLOOR = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_sel = 1'b1, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [3:0]  cfg_wait = '0;
  logic        busy, done, mem_dq_oe, mem_cs_n, mem_oe_n, mem_we_n;
  logic [7:0]  rd_data, mem_dq_o, mem_dq_i;
  logic [16:0] mem_addr;

  always #5 clk = ~clk;

  sram_async_ctrl #(.REF_INTERVAL(INTV), .REF_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_wait(cfg_wait), .busy(busy), .done(done), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n));

  // Memory model: data valid only once the read strobe has been low long enough.
  logic [7:0] mem [64];
  int oe_cnt = 0;
  always @(posedge clk) begin
    oe_cnt <= (!mem_cs_n && !mem_oe_n) ? oe_cnt + 1 : 0;
    if (!mem_cs_n && !mem_we_n) mem[mem_addr[5:0]] <= mem_dq_o;
  end
  assign mem_dq_i = (!mem_cs_n && !mem_oe_n && oe_cnt >= TB_FLOOR)
                    ? mem[mem_addr[5:0]] : 8'hEE;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog", 1'b0, 0, 1);
    finish_run();
  end

  // Results of the last access
  int  r_strobes, r_pre, r_post, r_split, r_badoe, r_first_lo, r_done_cyc;
  int  r_issue_busy;
  logic [7:0] r_data;
  int  prev_done = 0;

  task automatic do_access(input bit wr, input logic [16:0] a, input logic [7:0] d,
                           input logic [3:0] w);
    bit started, seen_strobe;
    started = 0; seen_strobe = 0;
    r_strobes = 0; r_pre = 0; r_post = 0; r_split = 0; r_badoe = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; cfg_wait = w;
    r_issue_busy = busy;
    while (busy) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (!mem_cs_n) begin
        if (!started) r_first_lo = cyc;
        started = 1;
        if (!mem_oe_n || !mem_we_n) begin
          seen_strobe = 1; r_strobes++;
          if (wr && (mem_dq_oe !== 1'b1 || mem_dq_o !== d)) r_badoe++;
        end else if (seen_strobe) r_post++;
        else r_pre++;
        if (!wr && mem_dq_oe) r_badoe++;
      end else if (started) r_split++;
      if (done) begin
        r_data = rd_data; r_done_cyc = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  // {write, addr[16:0], data[7:0], wait[3:0]}
  localparam logic [29:0] VEC [8] = '{
    {1'b1, 17'h00003, 8'hA5, 4'd0},
    {1'b1, 17'h1F00A, 8'h3C, 4'd3},
    {1'b0, 17'h00003, 8'h00, 4'd0},
    {1'b0, 17'h1F00A, 8'h00, 4'd5},
    {1'b1, 17'h00011, 8'hC3, 4'd1},
    {1'b1, 17'h0FFFF, 8'h7E, 4'd2},
    {1'b0, 17'h00011, 8'h00, 4'd15},
    {1'b0, 17'h0FFFF, 8'h00, 4'd1}
  };

  logic [7:0] shadow [64];

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", mem_cs_n === 1'b1, mem_cs_n, 1);
    chk("R1 oe_n/we_n", {mem_oe_n, mem_we_n} === 2'b11, {mem_oe_n, mem_we_n}, 3);
    chk("R1 dq_oe/busy/done", {mem_dq_oe, busy, done} === 3'b000,
        {mem_dq_oe, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    begin : vec_walk
      bit last_rd = 0;
      for (int i = 0; i < 8; i++) begin
        logic [29:0] v;
        int exp_s;
        v = VEC[i];
        do_access(v[29], v[28:12], v[11:4], v[3:0]);
        exp_s = ((int'(v[3:0]) < TB_FLOOR) ? TB_FLOOR : int'(v[3:0])) + 1;
        chk("R4 strobe width", r_strobes == exp_s, r_strobes, exp_s);
        chk("R3 setup/hold", r_pre == 1 && r_post == 1, r_pre * 10 + r_post, 11);
        chk("R10 cs held", r_split == 0, r_split, 0);
        chk("R6 data drive", r_badoe == 0, r_badoe, 0);
        if (v[29]) shadow[v[17:12]] = v[11:4];
        else chk("R5 read data", r_data == shadow[v[17:12]], r_data, shadow[v[17:12]]);
        if (v[29] && last_rd)
          chk("R7 turnaround", r_first_lo - prev_done - 1 >= 2,
              r_first_lo - prev_done - 1, 2);
        last_rd = !v[29];
        prev_done = r_done_cyc;
      end
    end

    // R2: unselected write is ignored
    begin : unsel
      int lo_seen = 0, done_seen = 0;
      while (busy) @(negedge clk);
      req_sel = 1'b0; req_valid = 1'b1; req_write = 1'b1;
      req_addr = 17'h00003; req_wdata = 8'h00; cfg_wait = 4'd0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (!mem_cs_n) lo_seen++;
        if (done) done_seen++;
      end
      req_valid = 1'b0; req_sel = 1'b1;
      chk("R2 cs stays high", lo_seen == 0, lo_seen, 0);
      chk("R2 no done", done_seen == 0, done_seen, 0);
      do_access(1'b0, 17'h00003, 8'h00, 4'd0);
      chk("R2 memory unchanged", r_data == 8'hA5, r_data, 8'hA5);
    end

    // R8: refresh window length and period while idle
    begin : refr
      int rise1, fall1, rise2, len_cs;
      while (busy) @(negedge clk);
      while (!busy) @(negedge clk);
      rise1 = cyc; len_cs = 0;
      while (busy) begin if (!mem_cs_n) len_cs++; @(negedge clk); end
      fall1 = cyc;
      while (!busy) @(negedge clk);
      rise2 = cyc;
      chk("R8 window length", fall1 - rise1 == GAP + 1, fall1 - rise1, GAP + 1);
      chk("R8 window cs high", len_cs == 0, len_cs, 0);
      chk("R8 period", rise2 - rise1 == INTV, rise2 - rise1, INTV);
      // R9: request issued in the window's first cycle
      do_access(1'b0, 17'h1F00A, 8'h00, 4'd1);
      chk("R9 stalled by busy", r_issue_busy == 1, r_issue_busy, 1);
      chk("R9 start after window", r_first_lo - rise2 == GAP + 2, r_first_lo - rise2, GAP + 2);
      chk("R9 read data", r_data == 8'h3C, r_data, 8'h3C);
    end

    // R10: long accesses across several refresh deadlines
    for (int k = 0; k < 6; k++) begin
      do_access(1'b0, 17'h00011, 8'h00, 4'd15);
      chk("R10 no split", r_split == 0, r_split, 0);
      chk("R5 long read", r_data == 8'hC3, r_data, 8'hC3);
    end

    finish_run();
  end
endmodule